// File: doc/BRIEF.md
# UART Receive Buffer with Ageing Timeout

This block sits between a UART deserializer and the register read port of the peripheral. Each received character comes in with its parity and framing error flags on a valid/ready input. The block stores it, together with its status bits, in a 32-entry first-in first-out queue. The register side sees the oldest entry combinationally and takes it with a one-cycle pop strobe. A line-break event comes in on a separate strobe. It is stored as a special character and does not depend on the receive enable.

The block drives five outputs for software:
- a receive-ready flag, which compares the fill level with a programmable trigger level;
- an empty flag;
- three sticky status bits, for overrun, break-detected and ageing timeout.

The ageing timer catches characters that stay below the trigger level too long. It runs only while the queue holds data and receive-ready is low. Every push or pop restarts it. After eight character times it raises the ageing status. The length of one character time is a programmable count of clock cycles.

Top module: `uart_rx_buffer`

## Requirements
- R1: `in_ready` is high exactly when `rx_en` is 1, fewer than 32 entries are in use, `brk_evt` is 0 and `soft_clr` is 0. A character is accepted only in a cycle where `in_valid` and `in_ready` are both high.
- R2: Entries leave in the order they were pushed. The word layout is: bits 7:0 data, bit 8 parity error, bit 9 framing error, bit 10 break, bit 11 overrun, bit 12 error. The error bit is the OR of bits 8 to 11.
- R3: A character pushed while exactly 31 entries are in use is stored with bits 11 and 12 forced to 1.
- R4: A pulse on `brk_evt` stores the word 0x1600 (data 0, with the break, framing and error bits set) if room remains, whatever the state of `rx_en`. Every break pulse sets the sticky `brk_sts`.
- R5: A break that arrives while 32 entries are in use is discarded and sets the sticky `ovr_sts`. The queue contents do not change.
- R6: After a push, `rx_rdy` is 1 if the occupancy is at least `trig_lvl`. After a pop, `rx_rdy` is 0 if the occupancy is below `trig_lvl`. Otherwise it holds.
- R7: While the queue is empty, `rd_word` reads 0. A pop of an empty queue changes no pointer and no flag.
- R8: `rx_empty` is 1 exactly when no entry is in use.
- R9: If the queue is non-empty with `rx_rdy` low, `age_sts` rises exactly 8×`char_cycles` clock cycles after the last push or pop. A `char_cycles` of 0 disables the timer.
- R10: The ageing timer never fires while the queue is empty or `rx_rdy` is 1. It fires only once per restart.
- R11: The sticky bits clear through the write-one-to-clear vector `sts_clr`: bit 0 clears overrun, bit 1 clears break, bit 2 clears ageing. A set in the same cycle wins over the clear.
- R12: After reset, and one cycle after `soft_clr`, the queue is empty, `rx_rdy` is 0 and the ageing timer is stopped. `soft_clr` leaves the sticky bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous queue clear |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Character present from the deserializer |
| in_ready | output | 1 | Character accepted this cycle when valid |
| in_data | input | 8 | Received character |
| in_par_err | input | 1 | Parity error of the character |
| in_frm_err | input | 1 | Framing error of the character |
| brk_evt | input | 1 | Line-break event strobe |
| trig_lvl | input | 6 | Receive-ready trigger level |
| char_cycles | input | 16 | Clock cycles per character time |
| rd_pop | input | 1 | Pop strobe from the register side |
| rd_word | output | 13 | Oldest entry, or 0 when empty |
| rx_empty | output | 1 | Queue empty |
| rx_rdy | output | 1 | Receive-ready flag |
| ovr_sts | output | 1 | Sticky overrun status |
| brk_sts | output | 1 | Sticky break status |
| age_sts | output | 1 | Sticky ageing timeout status |
| sts_clr | input | 3 | Write-one-to-clear for the sticky bits |

## Verification
The queue is filled and drained completely at every trigger level from 0 to 32. Because of this, a bad pointer or occupancy value shows up within one pop as a wrong `rd_word`, or as `rx_rdy` or `in_ready` flipping at the wrong fill level. A fault in the ageing counter shows up as `age_sts` rising one cycle early or late against the computed 8×`char_cycles` window. The timer is checked after a push and after a pop, and it is also checked that the timer stays quiet while `rx_rdy` is high or after a soft clear. An overrun or break fault is caught in the same cycle by the sticky bits, and later when the queue is drained and the stored words are compared with the expected ones.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int RXQ_DATA_W = 8;

  typedef struct packed {
    logic                  err;
    logic                  ovr;
    logic                  brk;
    logic                  frm;
    logic                  par;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_word_t;

  localparam int RXQ_WORD_W = $bits(rxq_word_t);

  // Assemble the stored word; a break replaces the character, the last slot
  // carries the overrun marking.
  function automatic rxq_word_t rxq_build(input logic [RXQ_DATA_W-1:0] data,
                                          input logic par,
                                          input logic frm,
                                          input logic brk,
                                          input logic last_slot);
    rxq_word_t w;
    w.data = brk ? '0 : data;
    w.par  = brk ? 1'b0 : par;
    w.frm  = brk | frm;
    w.brk  = brk;
    w.ovr  = last_slot;
    w.err  = w.par | w.frm | w.brk | w.ovr;
    return w;
  endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter  int DEPTH  = 32,
  parameter  int WORD_W = 13,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  occ
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  occ_q, occ_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      occ_d    = '0;
    end else begin
      if (wr_en) begin
        wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
      if (rd_en) begin
        rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
      unique case ({wr_en, rd_en})
        2'b10:   occ_d = occ_q + CNT_W'(1);
        2'b01:   occ_d = occ_q - CNT_W'(1);
        default: occ_d = occ_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  // Storage array carries no reset; an entry is only read after it is written.
  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      mem_q[wr_ptr_q] <= wr_word;
    end
  end

  assign head_word = mem_q[rd_ptr_q];
  assign occ       = occ_q;

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH));
  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (occ_q != CNT_W'(DEPTH)));
  assert_no_read_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (occ_q != '0));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] occ_after,
  input  logic [CNT_W-1:0] trig,
  input  logic             ovr_set,
  input  logic             brk_set,
  input  logic             age_set,
  input  logic [2:0]       sts_clr,
  output logic             rdy,
  output logic             ovr,
  output logic             brk,
  output logic             age
);

  logic rdy_q, rdy_d;
  logic ovr_q, ovr_d;
  logic brk_q, brk_d;
  logic age_q, age_d;

  always_comb begin
    rdy_d = rdy_q;
    if (clr) begin
      rdy_d = 1'b0;
    end else if (push && (occ_after >= trig)) begin
      rdy_d = 1'b1;
    end else if (pop && (occ_after < trig)) begin
      rdy_d = 1'b0;
    end
    ovr_d = ovr_set | (ovr_q & ~sts_clr[0]);
    brk_d = brk_set | (brk_q & ~sts_clr[1]);
    age_d = age_set | (age_q & ~sts_clr[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
      age_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      brk_q <= brk_d;
      age_q <= age_d;
    end
  end

  assign rdy = rdy_q;
  assign ovr = ovr_q;
  assign brk = brk_q;
  assign age = age_q;

  assert_brk_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |=> brk_q);
  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_q);
  assert_hold_without_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !sts_clr[0]) |=> ovr_q);
  assert_rdy_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rdy_q);

endmodule

// File: rtl/rxq_age_timer.sv
module rxq_age_timer #(
  parameter  int AGE_CHARS = 8,
  parameter  int DIV_W     = 16,
  localparam int AGE_W     = DIV_W + $clog2(AGE_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] char_cycles,
  output logic             fire
);

  logic [AGE_W-1:0] limit;
  logic [AGE_W-1:0] cnt_q, cnt_d;
  logic             enabled;
  logic             at_limit;

  assign limit    = AGE_W'(char_cycles) * AGE_W'(AGE_CHARS);
  assign enabled  = (char_cycles != '0);
  assign at_limit = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!run || restart || !enabled) begin
      cnt_d = '0;
    end else if (!at_limit) begin
      cnt_d = cnt_q + AGE_W'(1);
      fire  = (cnt_d == limit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fire);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxq_pkg::*;
#(
  parameter  int DEPTH     = 32,
  parameter  int AGE_CHARS = 8,
  parameter  int DIV_W     = 16,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_clr,
  input  logic                  rx_en,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [RXQ_DATA_W-1:0] in_data,
  input  logic                  in_par_err,
  input  logic                  in_frm_err,
  input  logic                  brk_evt,
  input  logic [CNT_W-1:0]      trig_lvl,
  input  logic [DIV_W-1:0]      char_cycles,
  input  logic                  rd_pop,
  output logic [RXQ_WORD_W-1:0] rd_word,
  output logic                  rx_empty,
  output logic                  rx_rdy,
  output logic                  ovr_sts,
  output logic                  brk_sts,
  output logic                  age_sts,
  input  logic [2:0]            sts_clr
);

  logic [CNT_W-1:0]      occ;
  logic [CNT_W-1:0]      occ_after;
  logic [RXQ_WORD_W-1:0] head_word;
  rxq_word_t             new_word;
  logic                  full, empty, last_slot;
  logic                  brk_push, data_push, wr_en, pop_en, ovr_set;
  logic                  age_run, age_restart, age_fire;

  assign full      = (occ == CNT_W'(DEPTH));
  assign empty     = (occ == '0);
  assign last_slot = (occ == CNT_W'(DEPTH - 1));

  assign in_ready  = rx_en && !full && !brk_evt && !soft_clr;
  assign data_push = in_valid && in_ready;
  assign brk_push  = brk_evt && !soft_clr;
  assign wr_en     = (data_push || brk_push) && !full;
  assign ovr_set   = brk_push && full;
  assign pop_en    = rd_pop && !empty && !soft_clr;

  assign new_word  = rxq_build(in_data, in_par_err, in_frm_err, brk_push, last_slot);

  always_comb begin
    occ_after = occ;
    if (wr_en && !pop_en) begin
      occ_after = occ + CNT_W'(1);
    end else if (pop_en && !wr_en) begin
      occ_after = occ - CNT_W'(1);
    end
  end

  rxq_storage #(
    .DEPTH  (DEPTH),
    .WORD_W (RXQ_WORD_W)
  ) storage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .wr_en     (wr_en),
    .wr_word   (new_word),
    .rd_en     (pop_en),
    .head_word (head_word),
    .occ       (occ)
  );

  rxq_flags #(
    .CNT_W (CNT_W)
  ) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .push      (wr_en),
    .pop       (pop_en),
    .occ_after (occ_after),
    .trig      (trig_lvl),
    .ovr_set   (ovr_set),
    .brk_set   (brk_evt),
    .age_set   (age_fire),
    .sts_clr   (sts_clr),
    .rdy       (rx_rdy),
    .ovr       (ovr_sts),
    .brk       (brk_sts),
    .age       (age_sts)
  );

  assign age_run     = !empty && !rx_rdy && !soft_clr;
  assign age_restart = wr_en || pop_en;

  rxq_age_timer #(
    .AGE_CHARS (AGE_CHARS),
    .DIV_W     (DIV_W)
  ) age_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (age_run),
    .restart     (age_restart),
    .char_cycles (char_cycles),
    .fire        (age_fire)
  );

  assign rd_word  = empty ? '0 : head_word;
  assign rx_empty = empty;

  assert_rdy_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_clr && (occ_after >= trig_lvl)) |=> rx_rdy);
  assert_age_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty || rx_rdy) |=> !$rose(age_sts));
  assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (rx_empty && !rx_rdy));
  assert_full_blocks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

endmodule

// File: tb/uart_rx_buffer_tb_top.sv
module uart_rx_buffer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int AGE_CHARS  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_clr, rx_en, in_valid, in_ready, in_par_err, in_frm_err;
  logic [7:0]  in_data;
  logic        brk_evt, rd_pop;
  logic [5:0]  trig_lvl;
  logic [15:0] char_cycles;
  logic [12:0] rd_word;
  logic        rx_empty, rx_rdy, ovr_sts, brk_sts, age_sts;
  logic [2:0]  sts_clr;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rx_en(rx_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .brk_evt(brk_evt),
    .trig_lvl(trig_lvl), .char_cycles(char_cycles), .rd_pop(rd_pop),
    .rd_word(rd_word), .rx_empty(rx_empty), .rx_rdy(rx_rdy),
    .ovr_sts(ovr_sts), .brk_sts(brk_sts), .age_sts(age_sts), .sts_clr(sts_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_word(input int d, input int p, input int f, input int ov);
    int e;
    e = (p | f | ov) & 1;
    return (e << 12) | (ov << 11) | (f << 9) | (p << 8) | (d & 255);
  endfunction

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic push(input int d, input int p, input int f);
    in_data = d[7:0]; in_par_err = p[0]; in_frm_err = f[0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input int exp);
    chk(tag, int'(rd_word), exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic qclear();
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_clr = 0; rx_en = 1; in_valid = 0; in_data = 0;
    in_par_err = 0; in_frm_err = 0; brk_evt = 0; trig_lvl = 6'd1;
    char_cycles = 16'd0; rd_pop = 0; sts_clr = 3'b000;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R12 / R8 / R1: state after reset
    chk("R12 reset empty", rx_empty, 1);
    chk("R12 reset rdy", rx_rdy, 0);
    chk("R12 reset sticky", {ovr_sts, brk_sts, age_sts}, 0);
    chk("R7 reset word", rd_word, 0);
    chk("R1 ready when enabled", in_ready, 1);
    rx_en = 0; #1;
    chk("R1 ready when disabled", in_ready, 0);
    rx_en = 1;

    // R2 R3 R6 R8: full fill/drain at every trigger level
    for (int t = 0; t <= DEPTH; t++) begin
      qclear();
      trig_lvl = t[5:0];
      for (int i = 0; i < DEPTH; i++) begin
        push((t * 13 + i * 7), i & 1, (i >> 1) & 1);
        chk("R6 rdy after push", rx_rdy, ((i + 1) >= t) ? 1 : 0);
        chk("R8 not empty", rx_empty, 0);
      end
      chk("R1 not ready when full", in_ready, 0);
      for (int j = 0; j < DEPTH; j++) begin
        pop_chk("R2 R3 order and layout",
                exp_word(t * 13 + j * 7, j & 1, (j >> 1) & 1, (j == DEPTH - 1) ? 1 : 0));
        chk("R6 rdy after pop", rx_rdy, ((DEPTH - 1 - j) >= t) ? 1 : 0);
      end
      chk("R8 empty after drain", rx_empty, 1);
      // R7: pop of empty queue
      pop_chk("R7 empty read zero", 0);
      chk("R7 empty pop keeps empty", rx_empty, 1);
      chk("R7 empty pop keeps rdy", rx_rdy, (t == 0) ? 1 : 0);
    end

    // R5 / R4: break while full
    qclear();
    trig_lvl = 6'd32;
    for (int i = 0; i < DEPTH; i++) push(i + 100, 0, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    tick(2);
    in_valid = 1'b0;
    chk("R1 full input not taken", in_ready, 0);
    brk_evt = 1'b1;
    tick(1);
    brk_evt = 1'b0;
    chk("R5 overrun sticky", ovr_sts, 1);
    chk("R4 break sticky on discard", brk_sts, 1);
    for (int j = 0; j < DEPTH; j++)
      pop_chk("R5 contents unchanged", exp_word(j + 100, 0, 0, (j == DEPTH - 1) ? 1 : 0));
    chk("R5 no extra entry", rx_empty, 1);

    // R11: write-one-to-clear, set wins
    sts_clr = 3'b001;
    tick(1);
    chk("R11 overrun cleared", ovr_sts, 0);
    chk("R11 break kept", brk_sts, 1);
    sts_clr = 3'b010; brk_evt = 1'b1; rx_en = 1'b0;
    tick(1);
    sts_clr = 3'b000; brk_evt = 1'b0;
    chk("R11 set wins over clear", brk_sts, 1);
    // R4: break stored while receive disabled
    chk("R1 disabled not ready", in_ready, 0);
    pop_chk("R4 break word", 32'h1600);
    chk("R4 break popped", rx_empty, 1);
    rx_en = 1'b1;
    sts_clr = 3'b010;
    tick(1);
    sts_clr = 3'b000;
    chk("R11 break cleared", brk_sts, 0);

    // R9: ageing after a push, 8 x 3 = 24 cycles
    char_cycles = 16'd3; trig_lvl = 6'd4;
    qclear();
    push(8'h41, 0, 0);
    tick(23);
    chk("R9 age not before limit", age_sts, 0);
    tick(1);
    chk("R9 age at limit", age_sts, 1);
    tick(30);
    sts_clr = 3'b100;
    tick(1);
    sts_clr = 3'b000;
    tick(30);
    chk("R10 age one shot", age_sts, 0);

    // R9: restart by push
    push(8'h42, 0, 0);
    tick(20);
    push(8'h43, 0, 0);
    tick(23);
    chk("R9 push restarts", age_sts, 0);
    tick(1);
    chk("R9 age after restart by push", age_sts, 1);
    sts_clr = 3'b100;
    tick(1);
    sts_clr = 3'b000;

    // R9: restart by pop
    pop_chk("R2 head after age", exp_word(8'h41, 0, 0, 0));
    tick(23);
    chk("R9 pop restarts", age_sts, 0);
    tick(1);
    chk("R9 age after restart by pop", age_sts, 1);
    sts_clr = 3'b100;
    tick(1);
    sts_clr = 3'b000;

    // R10: quiet while ready
    qclear();
    trig_lvl = 6'd1;
    push(8'h50, 0, 0);
    chk("R6 ready at level one", rx_rdy, 1);
    tick(40);
    chk("R10 no age while ready", age_sts, 0);

    // R9: zero char_cycles disables
    qclear();
    trig_lvl = 6'd8; char_cycles = 16'd0;
    push(8'h51, 0, 0);
    tick(60);
    chk("R9 disabled timer", age_sts, 0);

    // R12: soft clear stops timer mid-count
    char_cycles = 16'd3;
    qclear();
    push(8'h52, 0, 0); push(8'h53, 0, 0); push(8'h54, 0, 0);
    tick(10);
    qclear();
    chk("R12 soft clear empty", rx_empty, 1);
    chk("R12 soft clear rdy", rx_rdy, 0);
    chk("R12 soft clear word", rd_word, 0);
    tick(40);
    chk("R12 timer stopped", age_sts, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule